// File: doc/BRIEF.md
# Shadow-Pointer L2 Prefetch Engine

This block sits next to a shared second-level cache and watches the stream of demand misses that each first-level cache sends down. For every line it has seen requested, it keeps one pointer to the line that the same requester asked for next. A demand request is always answered on the shared reply bus first. The engine then follows the pointer chain from the demanded line and queues a few successor lines as prefetches for that requester.

Each first-level cache has its own small presence table. Prefetches for lines that cache already holds are dropped, so they never take a bus slot. An optional confirmation mode makes the engine use a pointer only after the same successor has been seen a second time. The data array, memory side and coherence logic are outside the block. A demand request is taken to be serviceable in the cycle it arrives.

Top module: `shadow_prefetch_engine`

## Requirements
- R1: Each requester has its own last-miss register. When requester k issues a demand for line L after an earlier demand for line P, the directory entry at index P[5:0] records P as tag and L as successor. If the entry already holds exactly that pair, it is marked confirmed instead. A requester's first demand after reset writes no entry.
- R2: A demand presented in cycle t appears on the reply bus after the clock edge ending t, with the request's line and ID and the prefetch flag at 0.
- R3: The pointer walk starts at the demanded line and follows up to DEPTH (default 3) successors, using the directory as it was before this cycle's update. It stops at the first entry that is invalid, whose tag differs from the line being looked up, or that is unconfirmed while confirmation mode is on.
- R4: With cfg_confirm at 1, a mapping seen only once yields no prefetch. A mapping seen twice in a row from the same predecessor does yield one.
- R5: A demand from requester k discards all of k's pending prefetches and replaces them with the new walk result. No queue ever holds more than PQ_DEPTH (4) lines.
- R6: No prefetch leaves in a cycle that carries a demand request. Otherwise one queue head is serviced per cycle, from the lowest-numbered requester with a non-empty queue.
- R7: A queue head already present in the target cache is removed without using the bus. Every line delivered to a requester, by demand or prefetch, is recorded as present for it, in a direct-mapped table indexed by line[3:0].
- R8: An eviction notice clears the presence record for that requester and line, so the line can be prefetched again. If the same entry is also being set in that cycle, the set wins.
- R9: After reset the bus is idle, and the directory, queues, last-miss registers and presence tables are empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_confirm | input | 1 | 1 = use only confirmed mappings |
| req_valid | input | 1 | Demand miss request present |
| req_id | input | ID_W | Requesting cache |
| req_line | input | LINE_W | Requested line address |
| evict_valid | input | 1 | Eviction notice present |
| evict_id | input | ID_W | Cache that dropped the line |
| evict_line | input | LINE_W | Line address dropped |
| bus_valid | output | 1 | Reply bus carries a line |
| bus_id | output | ID_W | Destination cache of the reply |
| bus_line | output | LINE_W | Line address on the reply bus |
| bus_pf | output | 1 | 1 = prefetch, 0 = demand reply |

## Verification
Four properties are checked on every cycle:
- a demand always takes the next bus slot with its own line and ID;
- a prefetch never follows a demand cycle;
- no queue grows past its capacity;
- a demand leaves its requester with at most DEPTH queued lines.

Only the bench scenarios can show the remaining behaviour:
- which lines a pointer chain actually yields;
- where the walk stops on a tag alias or an unconfirmed entry;
- that inclusion and eviction change what is sent;
- that a second demand cancels a pending chain.

A cycle-level reference model covers all of these. It is compared on every cycle during directed and random traffic, in both confirmation settings.

// File: rtl/shadow_prefetch_engine.sv
module shadow_prefetch_engine #(
  parameter int LINE_W       = 16,
  parameter int NREQ         = 2,
  parameter int DIR_ENTRIES  = 64,
  parameter int DEPTH        = 3,
  parameter int PQ_DEPTH     = 4,
  parameter int PRES_ENTRIES = 16,
  localparam int ID_W = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_confirm,
  input  logic              req_valid,
  input  logic [ID_W-1:0]   req_id,
  input  logic [LINE_W-1:0] req_line,
  input  logic              evict_valid,
  input  logic [ID_W-1:0]   evict_id,
  input  logic [LINE_W-1:0] evict_line,
  output logic              bus_valid,
  output logic [ID_W-1:0]   bus_id,
  output logic [LINE_W-1:0] bus_line,
  output logic              bus_pf
);
  // DEPTH must not exceed PQ_DEPTH
  localparam int DIR_IW  = $clog2(DIR_ENTRIES);
  localparam int PRES_IW = $clog2(PRES_ENTRIES);
  localparam int CNT_W   = $clog2(PQ_DEPTH + 1);

  logic [LINE_W-1:0] dir_tag  [DIR_ENTRIES];
  logic [LINE_W-1:0] dir_succ [DIR_ENTRIES];
  logic              dir_vld  [DIR_ENTRIES];
  logic              dir_cfm  [DIR_ENTRIES];

  logic [LINE_W-1:0] last_line [NREQ];
  logic              last_vld  [NREQ];

  logic [LINE_W-1:0] pq_line [NREQ][PQ_DEPTH];
  logic [CNT_W-1:0]  pq_cnt  [NREQ];

  logic [LINE_W-1:0] pres_tag [NREQ][PRES_ENTRIES];
  logic              pres_vld [NREQ][PRES_ENTRIES];

  // pointer walk over the directory as it stands before this cycle's update
  logic [LINE_W-1:0] walk_line [DEPTH];
  logic [CNT_W-1:0]  walk_cnt;

  always_comb begin
    logic [LINE_W-1:0] cur;
    logic              alive;
    logic [DIR_IW-1:0] wi;
    cur      = req_line;
    alive    = 1'b1;
    walk_cnt = '0;
    for (int h = 0; h < DEPTH; h++) begin
      wi    = cur[DIR_IW-1:0];
      alive = alive && dir_vld[wi] && (dir_tag[wi] == cur) && (!cfg_confirm || dir_cfm[wi]);
      walk_line[h] = dir_succ[wi];
      if (alive) walk_cnt = walk_cnt + CNT_W'(1);
      cur = dir_succ[wi];
    end
  end

  // prefetch service: lowest requester with work, only when no demand
  logic            sel_vld;
  logic [ID_W-1:0] sel_id;

  always_comb begin
    sel_vld = 1'b0;
    sel_id  = '0;
    for (int r = NREQ - 1; r >= 0; r--) begin
      if (!req_valid && pq_cnt[r] != '0) begin
        sel_vld = 1'b1;
        sel_id  = ID_W'(r);
      end
    end
  end

  logic [LINE_W-1:0]  head_line;
  logic [PRES_IW-1:0] head_pi;
  logic               head_present;
  logic               send_vld;
  logic [ID_W-1:0]    send_id;
  logic [LINE_W-1:0]  send_line;
  logic [PRES_IW-1:0] send_pi;

  assign head_line    = pq_line[sel_id][0];
  assign head_pi      = head_line[PRES_IW-1:0];
  assign head_present = pres_vld[sel_id][head_pi] && (pres_tag[sel_id][head_pi] == head_line);
  assign send_vld     = req_valid || (sel_vld && !head_present);
  assign send_id      = req_valid ? req_id : sel_id;
  assign send_line    = req_valid ? req_line : head_line;
  assign send_pi      = send_line[PRES_IW-1:0];

  // directory learning
  logic [LINE_W-1:0] prev_line;
  logic [DIR_IW-1:0] prev_di;
  logic              map_same;
  logic              learn;

  assign prev_line = last_line[req_id];
  assign prev_di   = prev_line[DIR_IW-1:0];
  assign map_same  = dir_vld[prev_di] && (dir_tag[prev_di] == prev_line) && (dir_succ[prev_di] == req_line);
  assign learn     = req_valid && last_vld[req_id];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DIR_ENTRIES; i++) begin
        dir_vld[i] <= 1'b0;
        dir_cfm[i] <= 1'b0;
      end
    end else if (learn) begin
      if (map_same) begin
        dir_cfm[prev_di] <= 1'b1;
      end else begin
        dir_vld[prev_di] <= 1'b1;
        dir_cfm[prev_di] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (learn && !map_same) begin
      dir_tag[prev_di]  <= prev_line;
      dir_succ[prev_di] <= req_line;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREQ; r++) last_vld[r] <= 1'b0;
    end else if (req_valid) begin
      last_vld[req_id]  <= 1'b1;
      last_line[req_id] <= req_line;
    end
  end

  // per-requester prefetch queues, head at slot 0
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREQ; r++) pq_cnt[r] <= '0;
    end else begin
      for (int r = 0; r < NREQ; r++) begin
        if (req_valid && req_id == ID_W'(r)) begin
          for (int h = 0; h < DEPTH; h++) pq_line[r][h] <= walk_line[h];
          pq_cnt[r] <= walk_cnt;
        end else if (sel_vld && sel_id == ID_W'(r)) begin
          for (int h = 0; h < PQ_DEPTH - 1; h++) pq_line[r][h] <= pq_line[r][h+1];
          pq_cnt[r] <= pq_cnt[r] - CNT_W'(1);
        end
      end
    end
  end

  // presence tables, set after clear so a delivery wins
  logic [PRES_IW-1:0] evict_pi;
  assign evict_pi = evict_line[PRES_IW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREQ; r++)
        for (int i = 0; i < PRES_ENTRIES; i++) pres_vld[r][i] <= 1'b0;
    end else begin
      if (evict_valid && pres_vld[evict_id][evict_pi] && pres_tag[evict_id][evict_pi] == evict_line)
        pres_vld[evict_id][evict_pi] <= 1'b0;
      if (send_vld) begin
        pres_vld[send_id][send_pi] <= 1'b1;
        pres_tag[send_id][send_pi] <= send_line;
      end
    end
  end

  // reply bus, one grant per cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_valid <= 1'b0;
      bus_id    <= '0;
      bus_line  <= '0;
      bus_pf    <= 1'b0;
    end else begin
      bus_valid <= send_vld;
      bus_id    <= send_id;
      bus_line  <= send_line;
      bus_pf    <= !req_valid;
    end
  end

  assert_demand_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (bus_valid && !bus_pf && bus_line == $past(req_line) && bus_id == $past(req_id)));

  assert_demand_blocks_pf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_pf) |-> !$past(req_valid));

  generate
    for (genvar g = 0; g < NREQ; g++) begin : g_qchk
      assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pq_cnt[g] <= CNT_W'(PQ_DEPTH));
      assert_flush_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_id == ID_W'(g)) |=> pq_cnt[g] <= CNT_W'(DEPTH));
    end
  endgenerate
endmodule

// File: tb/shadow_prefetch_engine_tb.sv
module shadow_prefetch_engine_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_confirm = 1'b0;
  logic        req_valid = 1'b0;
  logic [0:0]  req_id = '0;
  logic [15:0] req_line = '0;
  logic        evict_valid = 1'b0;
  logic [0:0]  evict_id = '0;
  logic [15:0] evict_line = '0;
  logic        bus_valid;
  logic [0:0]  bus_id;
  logic [15:0] bus_line;
  logic        bus_pf;

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_prefetch_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_confirm(cfg_confirm),
    .req_valid(req_valid), .req_id(req_id), .req_line(req_line),
    .evict_valid(evict_valid), .evict_id(evict_id), .evict_line(evict_line),
    .bus_valid(bus_valid), .bus_id(bus_id), .bus_line(bus_line), .bus_pf(bus_pf)
  );

  int errs = 0;
  int checks = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model
  logic [15:0] m_tag [64];
  logic [15:0] m_succ [64];
  bit          m_v [64];
  bit          m_c [64];
  logic [15:0] m_last [2];
  bit          m_lv [2];
  logic [15:0] m_q [2][$];
  logic [15:0] m_ptag [2][16];
  bit          m_pv [2][16];
  bit          m_bv, m_bpf;
  int          m_bid;
  logic [15:0] m_bline;
  logic [15:0] wl[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) begin m_v[i] = 0; m_c[i] = 0; end
      for (int r = 0; r < 2; r++) begin
        m_lv[r] = 0;
        m_q[r].delete();
        for (int i = 0; i < 16; i++) m_pv[r][i] = 0;
      end
      m_bv = 0; m_bpf = 0; m_bid = 0; m_bline = '0;
    end else begin
      logic [15:0] cur, hd, sln;
      bit alive, sv;
      int sel, sid, ix;
      wl.delete();
      cur = req_line;
      alive = 1;
      for (int h = 0; h < 3; h++) begin
        ix = int'(cur) % 64;
        alive = alive && m_v[ix] && m_tag[ix] == cur && (!cfg_confirm || m_c[ix]);
        if (alive) wl.push_back(m_succ[ix]);
        cur = m_succ[ix];
      end
      sel = -1;
      if (!req_valid)
        for (int r = 0; r < 2; r++) if (sel < 0 && m_q[r].size() > 0) sel = r;
      sv = 0; sid = 0; sln = '0;
      if (req_valid) begin
        sv = 1; sid = int'(req_id); sln = req_line;
      end else if (sel >= 0) begin
        hd = m_q[sel][0];
        if (!(m_pv[sel][int'(hd) % 16] && m_ptag[sel][int'(hd) % 16] == hd)) begin
          sv = 1; sid = sel; sln = hd;
        end
      end
      if (req_valid && m_lv[req_id]) begin
        ix = int'(m_last[req_id]) % 64;
        if (m_v[ix] && m_tag[ix] == m_last[req_id] && m_succ[ix] == req_line) m_c[ix] = 1;
        else begin
          m_tag[ix] = m_last[req_id]; m_succ[ix] = req_line; m_v[ix] = 1; m_c[ix] = 0;
        end
      end
      if (req_valid) begin m_last[req_id] = req_line; m_lv[req_id] = 1; end
      if (req_valid) m_q[req_id] = wl;
      else if (sel >= 0) void'(m_q[sel].pop_front());
      if (evict_valid) begin
        ix = int'(evict_line) % 16;
        if (m_pv[evict_id][ix] && m_ptag[evict_id][ix] == evict_line) m_pv[evict_id][ix] = 0;
      end
      if (sv) begin
        m_pv[sid][int'(sln) % 16] = 1;
        m_ptag[sid][int'(sln) % 16] = sln;
      end
      m_bv = sv; m_bid = sid; m_bline = sln; m_bpf = !req_valid;
    end
  end

  logic [16:0] pf_log[$];

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [31:0] act, exp;
      act = bus_valid ? {13'd0, 1'b1, bus_pf, bus_id, bus_line} : 32'd0;
      exp = m_bv ? {13'd0, 1'b1, m_bpf, m_bid[0], m_bline} : 32'd0;
      chk(act == exp, "R2 R6 per-cycle bus vs model", act, exp);
      if (bus_valid && bus_pf) pf_log.push_back({bus_id, bus_line});
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic demand(input int id, input logic [15:0] ln);
    req_valid = 1'b1; req_id = 1'(id); req_line = ln;
    tick();
    req_valid = 1'b0;
  endtask

  task automatic evict(input int id, input logic [15:0] ln);
    evict_valid = 1'b1; evict_id = 1'(id); evict_line = ln;
    tick();
    evict_valid = 1'b0;
  endtask

  task automatic check_log(input string tag, input int n, input logic [16:0] e0, input logic [16:0] e1, input logic [16:0] e2);
    logic [16:0] ex [3];
    ex[0] = e0; ex[1] = e1; ex[2] = e2;
    chk(pf_log.size() == n, {tag, " prefetch count"}, pf_log.size(), n);
    for (int i = 0; i < n && i < pf_log.size(); i++)
      chk(pf_log[i] == ex[i], {tag, " prefetch line"}, pf_log[i], ex[i]);
  endtask

  localparam logic [15:0] LA = 16'h0011, LB = 16'h0022, LC = 16'h0033, LD = 16'h0044;
  localparam logic [15:0] LE = 16'h0055, LP = 16'h0105, LQ = 16'h0117, LR = 16'h0129;
  localparam logic [15:0] LX = 16'h0145, LW = 16'h0088;

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk(bus_valid == 1'b0, "R9 bus idle after reset", bus_valid, 0);

    // train A->B->C->D on requester 0
    demand(0, LA);
    chk(bus_valid && !bus_pf && bus_line == LA && bus_id == 0, "R2 demand reply next cycle", bus_line, LA);
    repeat (4) tick();
    demand(0, LB); repeat (4) tick();
    demand(0, LC); repeat (4) tick();
    demand(0, LD); repeat (4) tick();
    chk(pf_log.size() == 0, "R1 R3 no chain before learning", pf_log.size(), 0);
    evict(0, LB); evict(0, LC); evict(0, LD);
    pf_log.delete();
    demand(0, LA); repeat (8) tick();
    check_log("R1 R3 R8 learned chain after eviction", 3, {1'b0, LB}, {1'b0, LC}, {1'b0, LD});

    // everything already present in cache 0
    pf_log.delete();
    demand(0, LB); repeat (8) tick();
    check_log("R7 present lines dropped", 0, '0, '0, '0);

    // requester 1 uses shared directory, own presence table
    pf_log.delete();
    demand(1, LB); repeat (8) tick();
    check_log("R7 R1 per-cache presence", 3, {1'b1, LC}, {1'b1, LD}, {1'b1, LA});

    // second demand cancels pending chain
    evict(0, LC); evict(0, LD); evict(0, LA);
    pf_log.delete();
    demand(0, LB);
    demand(0, LE);
    repeat (8) tick();
    check_log("R5 flush on new demand", 0, '0, '0, '0);

    // confirmation mode
    cfg_confirm = 1'b1;
    demand(1, LP); repeat (3) tick();
    demand(1, LQ); repeat (3) tick();
    demand(1, LR); repeat (3) tick();
    pf_log.delete();
    demand(1, LP); repeat (5) tick();
    demand(1, LQ); repeat (5) tick();
    demand(1, LR); repeat (5) tick();
    check_log("R4 unconfirmed mappings unused", 0, '0, '0, '0);
    evict(1, LQ); evict(1, LR);
    pf_log.delete();
    demand(1, LP); repeat (6) tick();
    check_log("R4 confirmed mappings used", 2, {1'b1, LQ}, {1'b1, LR}, '0);

    // tag mismatch stops the walk; demand beats prefetch
    cfg_confirm = 1'b0;
    pf_log.delete();
    demand(0, LX); repeat (5) tick();
    check_log("R3 alias tag mismatch stops walk", 0, '0, '0, '0);
    demand(0, LP);
    demand(1, LW);
    chk(bus_valid && !bus_pf && bus_line == LW, "R6 demand wins bus over queued prefetch", bus_line, LW);
    repeat (8) tick();
    check_log("R3 R7 depth walk with demand line dropped", 2, {1'b0, LQ}, {1'b0, LR}, '0);

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      if (n % 1000 == 500) cfg_confirm = ~cfg_confirm;
      req_valid   = ($urandom % 3) == 0;
      req_id      = 1'($urandom % 2);
      req_line    = 16'h0300 + 16'(($urandom % 24) * 7);
      evict_valid = ($urandom % 4) == 0;
      evict_id    = 1'($urandom % 2);
      evict_line  = 16'h0300 + 16'(($urandom % 24) * 7);
      tick();
    end
    req_valid = 1'b0; evict_valid = 1'b0;
    repeat (10) tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      errs++; checks++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule